// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the source and destination addresses of a two-channel DMA engine and sequences the address side of one transfer at a time. Each address is 20 bits wide. Software loads it through a 16-bit configuration port as a low word, which carries bits 15..0, and a high word, which carries bits 19..16. A per-channel control word selects the transfer width. It also selects, separately for source and destination, whether the address steps up, steps down or stays put once a transfer has completed.

A pulse on `xfer_start` launches a transfer on the channel given by `xfer_ch`. The sequencer is a six-state machine. It moves from ST_IDLE into ST_RD_A, where the source address is presented. Then it goes either to ST_RD_B, the second byte cycle of a split read, or straight to ST_WR_A, where the destination address is presented. From ST_WR_A it goes either to ST_WR_B, the second byte of a split write, or straight to ST_DONE. ST_DONE raises `xfer_done` for one cycle and then returns to ST_IDLE. A word transfer at an odd address is split into two byte cycles: the first at the address and the second at the address plus one.

Both addresses of the active channel are stepped on the clock edge that ends ST_DONE. The step is 2 for a word transfer and 1 for a byte transfer, and the arithmetic wraps modulo 2^20.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the sequencer is in ST_IDLE, with `busy`, `bus_valid` and `xfer_done` low, and every configuration register reads 0.
- R2: `cfg_sel` = {channel, index}. The index values are: 0 source low, 1 source high, 2 destination low, 3 destination high, 4 control. A low register reads back all 16 bits. A high register keeps only bits 3..0, ignores writes to bits 15..4 and returns 0 in them. The control register holds bits [1:0] source mode, [3:2] destination mode and [4] word (1) or byte (0), and reads 0 in bits 15..5.
- R3: `xfer_start` is accepted only in ST_IDLE, and `busy` is high from the cycle after acceptance until the sequencer is back in ST_IDLE. A start pulse while busy has no effect on the running sequence or on the other channel.
- R4: In the read cycles `bus_valid`=1, `bus_write`=0 and `bus_addr` is the source address. In the write cycles `bus_valid`=1, `bus_write`=1 and `bus_addr` is the destination address.
- R5: A word transfer at an even address uses a single cycle per phase, with `bus_word`=1 and `bus_split`=0.
- R6: A word transfer at an odd address uses two byte cycles per phase, with `bus_split`=1 and `bus_word`=0. The first cycle is at the address and the second at the address plus one, modulo 2^20.
- R7: A byte transfer uses one cycle per phase, with `bus_word`=0 and `bus_split`=0, whatever the address parity.
- R8: `xfer_done` is high for exactly one cycle, the cycle after the last write cycle, and `bus_valid` is low in that cycle. Updated addresses read back from the following cycle on.
- R9: Mode codes are 00 hold, 01 increment, 10 decrement and 11 hold. Source and destination follow their own modes independently.
- R10: The step is 2 for word transfers and 1 for byte transfers. The update wraps modulo 2^20, and a carry or borrow across bit 15 reaches bits 19..16.
- R11: A transfer or a register write on one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | {channel, register index} |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| xfer_start | input | 1 | Start a transfer |
| xfer_ch | input | 1 | Channel of the transfer |
| busy | output | 1 | Sequencer not idle |
| bus_valid | output | 1 | Bus address cycle active |
| bus_write | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | 20 | Address of the current bus cycle |
| bus_word | output | 1 | 16-bit access in this cycle |
| bus_split | output | 1 | Cycle belongs to a split odd word access |
| xfer_done | output | 1 | Transfer completed, addresses step next edge |

## Verification
The bench sweeps every combination of channel, source mode, destination mode and width. Each combination runs over base addresses at 0, 0x0FFFF, 0x10000, 0xFFFFF and an odd and an even interior value. Even and odd bases under word width separate the single-cycle path from the split path, and byte width shows that parity is then irrelevant. The extreme bases show whether the step carries across bit 15 and wraps at both ends of the 20-bit space, including a second byte cycle that wraps to zero. Pairing different source and destination bases with different modes exposes any cross-coupling between the two address updates or between the two channels.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_INC  = 2'b01,
        MODE_DEC  = 2'b10,
        MODE_RSVD = 2'b11
    } step_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_WR_A,
        ST_WR_B,
        ST_DONE
    } seq_state_e;

    localparam int unsigned REG_IDX_W = 3;
    localparam logic [REG_IDX_W-1:0] RI_SRC_LO = 3'd0;
    localparam logic [REG_IDX_W-1:0] RI_SRC_HI = 3'd1;
    localparam logic [REG_IDX_W-1:0] RI_DST_LO = 3'd2;
    localparam logic [REG_IDX_W-1:0] RI_DST_HI = 3'd3;
    localparam logic [REG_IDX_W-1:0] RI_CTRL   = 3'd4;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic [AW-1:0] cur_addr,
    input  step_mode_e    mode,
    input  logic          word_sz,
    output logic [AW-1:0] next_addr
);
    logic [AW-1:0] stride;

    assign stride = word_sz ? AW'(2) : AW'(1);

    // R9 R10: full-width add/subtract, wraps modulo 2^AW
    always_comb begin
        unique case (mode)
            MODE_INC: next_addr = cur_addr + stride;
            MODE_DEC: next_addr = cur_addr - stride;
            default:  next_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 upd,
    output logic [AW-1:0]        src_addr,
    output logic [AW-1:0]        dst_addr,
    output logic                 word_sz
);
    localparam int unsigned HI_W = AW - DW;

    logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
    step_mode_e    smode_q, dmode_q;
    logic          word_q;

    dma_addr_step #(.AW(AW)) u_src_step (
        .cur_addr (src_q),
        .mode     (smode_q),
        .word_sz  (word_q),
        .next_addr(src_nx)
    );

    dma_addr_step #(.AW(AW)) u_dst_step (
        .cur_addr (dst_q),
        .mode     (dmode_q),
        .word_sz  (word_q),
        .next_addr(dst_nx)
    );

    // Register writes take priority over the post-transfer update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            smode_q <= MODE_HOLD;
            dmode_q <= MODE_HOLD;
            word_q  <= 1'b0;
        end else if (we) begin
            unique case (idx)
                RI_SRC_LO: src_q[DW-1:0]  <= wdata;
                RI_SRC_HI: src_q[AW-1:DW] <= wdata[HI_W-1:0];
                RI_DST_LO: dst_q[DW-1:0]  <= wdata;
                RI_DST_HI: dst_q[AW-1:DW] <= wdata[HI_W-1:0];
                RI_CTRL: begin
                    smode_q <= step_mode_e'(wdata[1:0]);
                    dmode_q <= step_mode_e'(wdata[3:2]);
                    word_q  <= wdata[4];
                end
                default: ;
            endcase
        end else if (upd) begin
            src_q <= src_nx;
            dst_q <= dst_nx;
        end
    end

    always_comb begin
        unique case (idx)
            RI_SRC_LO: rdata = src_q[DW-1:0];
            RI_SRC_HI: rdata = DW'(src_q[AW-1:DW]);
            RI_DST_LO: rdata = dst_q[DW-1:0];
            RI_DST_HI: rdata = DW'(dst_q[AW-1:DW]);
            RI_CTRL:   rdata = DW'({word_q, dmode_q, smode_q});
            default:   rdata = '0;
        endcase
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;
    assign word_sz  = word_q;
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW     = 20,
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CHW    = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] start_ch,
    output logic [CHW-1:0] act_ch,
    input  logic [AW-1:0]  cur_src,
    input  logic [AW-1:0]  cur_dst,
    input  logic           cur_word,
    output logic           busy,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_word,
    output logic           bus_split,
    output logic           done
);
    seq_state_e     state_q, state_d;
    logic [CHW-1:0] ch_q;
    logic           ch_ok, src_split, dst_split;

    assign ch_ok     = ({1'b0, start_ch} < (CHW+1)'(NUM_CH));
    assign src_split = cur_word & cur_src[0];
    assign dst_split = cur_word & cur_dst[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start && ch_ok) ch_q <= start_ch;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && ch_ok) state_d = ST_RD_A;
            ST_RD_A: state_d = src_split ? ST_RD_B : ST_WR_A;
            ST_RD_B: state_d = ST_WR_A;
            ST_WR_A: state_d = dst_split ? ST_WR_B : ST_DONE;
            ST_WR_B: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_word  = 1'b0;
        bus_split = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_A: begin
                bus_valid = 1'b1;
                bus_addr  = cur_src;
                bus_word  = cur_word & ~src_split;
                bus_split = src_split;
            end
            ST_RD_B: begin
                bus_valid = 1'b1;
                bus_addr  = cur_src + AW'(1);
                bus_split = 1'b1;
            end
            ST_WR_A: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = cur_dst;
                bus_word  = cur_word & ~dst_split;
                bus_split = dst_split;
            end
            ST_WR_B: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = cur_dst + AW'(1);
                bus_split = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign busy   = (state_q != ST_IDLE);
    assign act_ch = ch_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned AW     = 20,
    parameter int unsigned DW     = 16,
    localparam int unsigned CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned SELW  = CHW + REG_IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            xfer_start,
    input  logic [CHW-1:0]  xfer_ch,
    output logic            busy,
    output logic            bus_valid,
    output logic            bus_write,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_word,
    output logic            bus_split,
    output logic            xfer_done
);
    logic [CHW-1:0]       sel_ch, act_ch;
    logic [REG_IDX_W-1:0] sel_idx;
    logic [DW-1:0]        rd_arr  [NUM_CH];
    logic [AW-1:0]        src_arr [NUM_CH];
    logic [AW-1:0]        dst_arr [NUM_CH];
    logic                 word_arr[NUM_CH];
    logic                 done_w;

    assign sel_ch  = cfg_sel[SELW-1:REG_IDX_W];
    assign sel_idx = cfg_sel[REG_IDX_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dma_addr_chan #(.AW(AW), .DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cfg_we && (sel_ch == CHW'(i))),
            .idx     (sel_idx),
            .wdata   (cfg_wdata),
            .rdata   (rd_arr[i]),
            .upd     (done_w && (act_ch == CHW'(i))),
            .src_addr(src_arr[i]),
            .dst_addr(dst_arr[i]),
            .word_sz (word_arr[i])
        );
    end

    assign cfg_rdata = ({1'b0, sel_ch} < (CHW+1)'(NUM_CH)) ? rd_arr[sel_ch] : '0;

    dma_addr_seq #(.AW(AW), .NUM_CH(NUM_CH), .CHW(CHW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .start_ch (xfer_ch),
        .act_ch   (act_ch),
        .cur_src  (src_arr[act_ch]),
        .cur_dst  (dst_arr[act_ch]),
        .cur_word (word_arr[act_ch]),
        .busy     (busy),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_word (bus_word),
        .bus_split(bus_split),
        .done     (done_w)
    );

    assign xfer_done = done_w;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int unsigned AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic          busy,
    input logic          bus_valid,
    input logic [AW-1:0] bus_addr,
    input logic          bus_word,
    input logic          bus_split,
    input logic          xfer_done
);
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid && !xfer_done); // R3

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !busy) |=> busy); // R3

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_word) |-> !bus_addr[0]); // R5

    AST_SPLIT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_split |-> !bus_word); // R6

    AST_SPLIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_split && bus_addr[0]) |=>
        (bus_valid && bus_split && bus_addr == ($past(bus_addr) + AW'(1)))); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !bus_valid); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done && !busy); // R8
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_start(xfer_start),
    .busy      (busy),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_word  (bus_word),
    .bus_split (bus_split),
    .xfer_done (xfer_done)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        xfer_start = 1'b0;
    logic        xfer_ch = 1'b0;
    logic        busy, bus_valid, bus_write, bus_word, bus_split, xfer_done;
    logic [19:0] bus_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_start(xfer_start),
        .xfer_ch(xfer_ch), .busy(busy), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_word(bus_word),
        .bus_split(bus_split), .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Both tasks start and end just after a falling edge.
    task automatic wr(input int ch, input int idx, input logic [15:0] val);
        cfg_we = 1'b1; cfg_sel = 4'(ch * 8 + idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int idx, output logic [15:0] val);
        cfg_sel = 4'(ch * 8 + idx);
        #1;
        val = cfg_rdata;
    endtask

    task automatic set_addr(input int ch, input int lo_idx, input logic [19:0] a);
        wr(ch, lo_idx, a[15:0]);
        wr(ch, lo_idx + 1, {12'hFFF, a[19:16]});  // junk above bit 3 must be dropped
    endtask

    task automatic get_addr(input int ch, input int lo_idx, output logic [19:0] a);
        logic [15:0] lo, hi;
        rd(ch, lo_idx, lo);
        rd(ch, lo_idx + 1, hi);
        chk("R2", 32'(hi[15:4]), 32'd0);
        a = {hi[3:0], lo};
    endtask

    function automatic logic [19:0] stepped(input logic [19:0] a, input int mode, input bit w);
        logic [19:0] st = w ? 20'd2 : 20'd1;
        if (mode == 1) return a + st;
        if (mode == 2) return a - st;
        return a;
    endfunction

    task automatic bus_cyc(input logic [19:0] a, input bit wr_ph, input bit w, input bit second);
        bit split = w && a[0] && !second;
        chk("R4", 32'(bus_valid), 32'd1);
        chk("R4", 32'(bus_write), 32'(wr_ph));
        chk(second ? "R6" : "R4", 32'(bus_addr), 32'(a));
        chk(w ? ((a[0] || second) ? "R6" : "R5") : "R7", 32'(bus_word),
            32'(w && !a[0] && !second));
        chk(w ? "R6" : "R7", 32'(bus_split), 32'(split || second));
        @(negedge clk);
    endtask

    task automatic phase(input logic [19:0] a, input bit wr_ph, input bit w);
        if (w && a[0]) begin
            bus_cyc(a, wr_ph, w, 1'b0);
            bus_cyc(a + 20'd1, wr_ph, w, 1'b1);
        end else begin
            bus_cyc(a, wr_ph, w, 1'b0);
        end
    endtask

    task automatic run_xfer(input int ch, input logic [19:0] sa, input logic [19:0] da,
                            input bit w, input int sm, input int dm);
        logic [19:0] got, oth;
        set_addr(ch, 0, sa);
        set_addr(ch, 2, da);
        wr(ch, 4, 16'(((w ? 1 : 0) << 4) | (dm << 2) | sm));
        xfer_start = 1'b1; xfer_ch = 1'(ch);
        @(negedge clk);
        xfer_start = 1'b0;
        phase(sa, 1'b0, w);
        phase(da, 1'b1, w);
        chk("R8", 32'(xfer_done), 32'd1);
        chk("R8", 32'(bus_valid), 32'd0);
        get_addr(ch, 0, got);
        chk("R8", 32'(got), 32'(sa));
        @(negedge clk);
        chk("R8", 32'(xfer_done), 32'd0);
        chk("R3", 32'(busy), 32'd0);
        get_addr(ch, 0, got);
        chk((sm == 1 || sm == 2) ? "R10" : "R9", 32'(got), 32'(stepped(sa, sm, w)));
        get_addr(ch, 2, got);
        chk((dm == 1 || dm == 2) ? "R10" : "R9", 32'(got), 32'(stepped(da, dm, w)));
        get_addr(1 - ch, 0, oth);
        chk("R11", 32'(oth), 32'h5A5A5);
        get_addr(1 - ch, 2, oth);
        chk("R11", 32'(oth), 32'hA5A5A);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic [19:0] a;
        logic [19:0] bases [6] = '{20'h00000, 20'h0FFFF, 20'h10000,
                                   20'hFFFFF, 20'h2A5A4, 20'h13571};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(busy), 32'd0);
        chk("R1", 32'(bus_valid), 32'd0);
        chk("R1", 32'(xfer_done), 32'd0);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 5; i++) begin
                rd(c, i, v);
                chk("R1", 32'(v), 32'd0);
            end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: register widths and reserved bits
        wr(0, 1, 16'hFFFF); rd(0, 1, v); chk("R2", 32'(v), 32'h000F);
        wr(0, 0, 16'hBEEF); rd(0, 0, v); chk("R2", 32'(v), 32'hBEEF);
        wr(0, 4, 16'hFFFF); rd(0, 4, v); chk("R2", 32'(v), 32'h001F);
        wr(0, 3, 16'h0A05); rd(0, 3, v); chk("R2", 32'(v), 32'h0005);
        rd(1, 1, v); chk("R11", 32'(v), 32'd0);
        rd(1, 4, v); chk("R11", 32'(v), 32'd0);

        // R3: start while busy is ignored
        set_addr(0, 0, 20'h00100); set_addr(0, 2, 20'h00200); wr(0, 4, 16'h0000);
        set_addr(1, 0, 20'h00300); wr(1, 4, 16'h0005);
        xfer_start = 1'b1; xfer_ch = 1'b0;
        @(negedge clk);
        xfer_start = 1'b1; xfer_ch = 1'b1;
        chk("R3", 32'(busy), 32'd1);
        chk("R3", 32'(bus_addr), 32'h00100);
        @(negedge clk);
        xfer_start = 1'b0;
        chk("R3", 32'(bus_write), 32'd1);
        chk("R3", 32'(bus_addr), 32'h00200);
        @(negedge clk);
        chk("R3", 32'(xfer_done), 32'd1);
        @(negedge clk);
        chk("R3", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R3", 32'(busy), 32'd0);
        chk("R3", 32'(bus_valid), 32'd0);
        get_addr(1, 0, a); chk("R3", 32'(a), 32'h00300);

        // Sweep: channel x modes x width x bases
        for (int ch = 0; ch < 2; ch++) begin
            set_addr(1 - ch, 0, 20'h5A5A5);
            set_addr(1 - ch, 2, 20'hA5A5A);
            wr(1 - ch, 4, 16'h0015);
            for (int sm = 0; sm < 4; sm++)
                for (int dm = 0; dm < 4; dm++)
                    for (int w = 0; w < 2; w++)
                        for (int k = 0; k < 6; k++)
                            run_xfer(ch, bases[k], bases[(k + 2) % 6], w != 0, sm, dm);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule